// File: doc/BRIEF.md
# Serial DAC Command Word Receiver

This block takes 32-bit command words for a multi-channel digital-to-analog converter over a three-wire serial link: an active-low frame select, a serial clock and a data line. The three serial lines are brought into the system clock domain by synchronizers. Frame-select and serial-clock edges are detected in that domain. One data bit is taken, most significant bit first, on each falling serial-clock edge of an open frame.

Once 32 bits have arrived, the word locks. It is split into a control nibble, a channel address nibble and a left-aligned 16-bit code, and a one-cycle command strobe is raised. The select line does not need to rise first. The code bits below the configured resolution (16, 14 or 12 bits) are cleared. A frame that closes before its 32nd bit is discarded and is flagged with a one-cycle error pulse.

The system clock must run at least four times as fast as the serial clock.

Top module: `dac_cmd_rx`

## Requirements
- R1: A word is collected only after a falling edge of `sel_ni`. Serial-clock edges seen while `sel_ni` is high, or before the first falling edge of `sel_ni` after reset, produce neither a command nor an error.
- R2: On each falling edge of `sclk_i` inside a frame, one bit is taken from `din_i`, most significant bit first. Word bits 27:24 appear on `ctrl_o`, bits 23:20 on `addr_o`, and bits 19:4 on `data_o[15:0]`.
- R3: After the 32nd bit the word is locked. Further serial-clock edges in the same frame change no output and raise no second strobe, and the internal bit count never exceeds 32.
- R4: `cmd_valid_o` is high for exactly one system clock cycle, no more than 5 system clock cycles after the 32nd falling serial-clock edge, whether or not `sel_ni` has risen.
- R5: When `sel_ni` rises with fewer than 32 bits received, `frame_error_o` pulses for one cycle. No command is issued and `ctrl_o`, `addr_o` and `data_o` keep their previous values.
- R6: With parameter `RES_BITS` set to 16, 14 or 12, the lowest 16-`RES_BITS` bits of `data_o` are zero, so word bits 3:0, 5:0 or 7:0 respectively are ignored.
- R7: Word bits 31:28, including bit 31, have no effect on any output.
- R8: After reset `cmd_valid_o`, `frame_error_o`, `ctrl_o`, `addr_o` and `data_o` are zero. The field outputs change only in the cycle that `cmd_valid_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_ni | input | 1 | Serial frame select, active low |
| sclk_i | input | 1 | Serial clock, data taken on falling edge |
| din_i | input | 1 | Serial data, MSB first |
| cmd_valid_o | output | 1 | One-cycle command strobe |
| ctrl_o | output | 4 | Control field of the last command |
| addr_o | output | 4 | Channel address of the last command |
| data_o | output | 16 | Left-aligned code, low unused bits cleared |
| frame_error_o | output | 1 | One-cycle pulse for a short, discarded frame |

## Verification
The assertions take three things for granted. First, each serial-clock level and each data bit lasts at least two system clock cycles. Second, `din_i` is stable around every falling edge of `sclk_i`. Third, `sel_ni` does not toggle again before the synchronizers have carried its previous edge through. The stimulus keeps within these limits by moving every serial line on the falling system clock edge only. It holds each serial-clock phase for three system cycles and changes data only while the serial clock is high. It also leaves ten idle cycles after each rise of select.

// File: rtl/dac_cmd_rx_pkg.sv
package dac_cmd_rx_pkg;
  localparam int WORD_W   = 32;
  localparam int PREFIX_W = 4;
  localparam int CTRL_W   = 4;
  localparam int ADDR_W   = 4;
  localparam int CODE_W   = 16;
  localparam int KEEP_W   = WORD_W - PREFIX_W;
  localparam int TAIL_W   = KEEP_W - CTRL_W - ADDR_W - CODE_W;
  localparam int CNT_W    = $clog2(WORD_W + 1);

  typedef struct packed {
    logic [CTRL_W-1:0] ctrl;
    logic [ADDR_W-1:0] addr;
    logic [CODE_W-1:0] code;
  } cmd_t;
endpackage

// File: rtl/dac_rx_sync.sv
module dac_rx_sync #(
  parameter int              WIDTH   = 3,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < STAGES; k++) stg_q[k] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int k = 1; k < STAGES; k++) stg_q[k] <= stg_q[k-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/dac_rx_frame.sv
module dac_rx_frame
  import dac_cmd_rx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_n_i,
  input  logic              sclk_i,
  input  logic              din_i,
  output logic              sel_rise_o,
  output logic              open_o,
  output logic [CNT_W-1:0]  bit_cnt_o,
  output logic              done_o,
  output logic [KEEP_W-1:0] word_o
);
  logic              sel_q, sclk_q, open_q, done_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [KEEP_W-1:0] sr_q;
  logic              sel_fall, sel_rise, sclk_fall, full, shift_en;

  assign sel_fall  = sel_q & ~sel_n_i;
  assign sel_rise  = ~sel_q & sel_n_i;
  assign sclk_fall = sclk_q & ~sclk_i;
  assign full      = (cnt_q == CNT_W'(WORD_W));
  assign shift_en  = sclk_fall & open_q & ~full;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= 1'b1;
      sclk_q <= 1'b1;
      open_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      sr_q   <= '0;
    end else begin
      sel_q  <= sel_n_i;
      sclk_q <= sclk_i;
      done_q <= 1'b0;
      if (sel_fall) begin
        open_q <= 1'b1;
        cnt_q  <= '0;
      end else if (sel_rise) begin
        open_q <= 1'b0;
        cnt_q  <= '0;
      end else if (shift_en) begin
        // prefix bits fall off the top of the 28-bit register
        sr_q   <= {sr_q[KEEP_W-2:0], din_i};
        cnt_q  <= cnt_q + 1'b1;
        done_q <= (cnt_q == CNT_W'(WORD_W - 1));
      end
    end
  end

  assign sel_rise_o = sel_rise;
  assign open_o     = open_q;
  assign bit_cnt_o  = cnt_q;
  assign done_o     = done_q;
  assign word_o     = sr_q;
endmodule

// File: rtl/dac_rx_decode.sv
module dac_rx_decode
  import dac_cmd_rx_pkg::*;
#(
  parameter int RES_BITS = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  logic [KEEP_W-1:0] word_i,
  output logic              valid_o,
  output cmd_t              cmd_o
);
  localparam int               DROP_W    = CODE_W - RES_BITS;
  localparam logic [CODE_W-1:0] CODE_MASK = {CODE_W{1'b1}} << DROP_W;

  cmd_t nxt;

  always_comb begin
    nxt.ctrl = word_i[KEEP_W-1 -: CTRL_W];
    nxt.addr = word_i[KEEP_W-CTRL_W-1 -: ADDR_W];
    nxt.code = word_i[TAIL_W +: CODE_W] & CODE_MASK;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      cmd_o   <= '0;
    end else begin
      valid_o <= done_i;
      if (done_i) cmd_o <= nxt;
    end
  end
endmodule

// File: rtl/dac_cmd_rx.sv
module dac_cmd_rx
  import dac_cmd_rx_pkg::*;
#(
  parameter int RES_BITS    = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        sel_ni,
  input  logic        sclk_i,
  input  logic        din_i,
  output logic        cmd_valid_o,
  output logic [3:0]  ctrl_o,
  output logic [3:0]  addr_o,
  output logic [15:0] data_o,
  output logic        frame_error_o
);
  logic [2:0]        pins_s;
  logic              sel_rise, frame_open, word_done, err_q;
  logic [CNT_W-1:0]  bit_cnt;
  logic [KEEP_W-1:0] word;
  cmd_t              cmd;

  dac_rx_sync #(
    .WIDTH  (3),
    .STAGES (SYNC_STAGES),
    .RST_VAL(3'b110)
  ) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sel_ni, sclk_i, din_i}),
    .q_o   (pins_s)
  );

  dac_rx_frame u_frame (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sel_n_i   (pins_s[2]),
    .sclk_i    (pins_s[1]),
    .din_i     (pins_s[0]),
    .sel_rise_o(sel_rise),
    .open_o    (frame_open),
    .bit_cnt_o (bit_cnt),
    .done_o    (word_done),
    .word_o    (word)
  );

  dac_rx_decode #(.RES_BITS(RES_BITS)) u_decode (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .done_i (word_done),
    .word_i (word),
    .valid_o(cmd_valid_o),
    .cmd_o  (cmd)
  );

  // short frame: select closes an open frame before the word is full
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else         err_q <= sel_rise & frame_open & (bit_cnt != CNT_W'(WORD_W));
  end

  assign frame_error_o = err_q;
  assign ctrl_o        = cmd.ctrl;
  assign addr_o        = cmd.addr;
  assign data_o        = cmd.code;
endmodule

// File: rtl/dac_cmd_rx_chk.sv
module dac_cmd_rx_chk
  import dac_cmd_rx_pkg::*;
#(
  parameter int RES_BITS = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cmd_valid_i,
  input logic             frame_error_i,
  input logic [3:0]       ctrl_i,
  input logic [3:0]       addr_i,
  input logic [15:0]      data_i,
  input logic [CNT_W-1:0] bit_cnt_i,
  input logic             sel_rise_i
);
  localparam int DROP_W = CODE_W - RES_BITS;

  AST_CNT_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_cnt_i <= CNT_W'(WORD_W)); // R3
  AST_LOCK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_cnt_i == CNT_W'(WORD_W) && !sel_rise_i) |=> bit_cnt_i == CNT_W'(WORD_W)); // R3
  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i |=> !cmd_valid_i); // R4
  AST_VALID_AFTER_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i |-> $past(bit_cnt_i) == CNT_W'(WORD_W)); // R4
  AST_ERR_SHORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_error_i |-> $past(bit_cnt_i) != CNT_W'(WORD_W)); // R5
  AST_ERR_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_error_i |=> !frame_error_i); // R5
  AST_ERR_NO_CMD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(frame_error_i && cmd_valid_i)); // R5
  AST_FIELDS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable({ctrl_i, addr_i, data_i}) |-> cmd_valid_i); // R8

  if (DROP_W > 0) begin : g_low
    AST_LOW_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      data_i[DROP_W-1:0] == '0); // R6
  end
endmodule

bind dac_cmd_rx dac_cmd_rx_chk #(.RES_BITS(RES_BITS)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cmd_valid_i  (cmd_valid_o),
  .frame_error_i(frame_error_o),
  .ctrl_i       (ctrl_o),
  .addr_i       (addr_o),
  .data_i       (data_o),
  .bit_cnt_i    (bit_cnt),
  .sel_rise_i   (sel_rise)
);

// File: tb/dac_cmd_rx_test.sv
`timescale 1ns/1ps
module dac_cmd_rx_test;
  localparam int HALF = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sel_n = 1'b1, sclk = 1'b1, din = 1'b0;
  logic        v16, e16, v12, e12;
  logic [3:0]  c16, a16, c12, a12;
  logic [15:0] d16, d12;

  int n_chk = 0, n_fail = 0;
  int n_cmd16 = 0, n_cmd12 = 0, n_err16 = 0, n_err12 = 0;
  bit fin = 1'b0;

  always #5 clk = ~clk;

  dac_cmd_rx #(.RES_BITS(16)) uut (
    .clk_i(clk), .rst_ni(rst_n), .sel_ni(sel_n), .sclk_i(sclk), .din_i(din),
    .cmd_valid_o(v16), .ctrl_o(c16), .addr_o(a16), .data_o(d16), .frame_error_o(e16));

  dac_cmd_rx #(.RES_BITS(12)) uut12 (
    .clk_i(clk), .rst_ni(rst_n), .sel_ni(sel_n), .sclk_i(sclk), .din_i(din),
    .cmd_valid_o(v12), .ctrl_o(c12), .addr_o(a12), .data_o(d12), .frame_error_o(e12));

  always @(negedge clk) begin
    if (v16) n_cmd16++;
    if (v12) n_cmd12++;
    if (e16) n_err16++;
    if (e12) n_err12++;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic sclk_pulse(input logic b);
    din = b;
    wait_cyc(HALF);
    sclk = 1'b0;
    wait_cyc(HALF);
    sclk = 1'b1;
  endtask

  task automatic send(input logic [31:0] w, input int nbits, input int extra, input bit close);
    sel_n = 1'b0;
    wait_cyc(HALF);
    for (int i = 0; i < nbits; i++) sclk_pulse(w[31-i]);
    for (int i = 0; i < extra; i++) sclk_pulse(~w[i]);
    wait_cyc(HALF);
    if (close) begin
      sel_n = 1'b1;
      wait_cyc(2*HALF + 4);
    end
  endtask

  function automatic logic [31:0] mk(input int c, input int a, input logic [15:0] d);
    return {4'(c + a), 4'(c), 4'(a), d, 4'hA};
  endfunction

  task automatic cmp_word(input string req, input logic [31:0] w);
    chk({req, " ctrl"}, 32'(c16), 32'(w[27:24]));
    chk({req, " addr"}, 32'(a16), 32'(w[23:20]));
    chk({req, " data16"}, 32'(d16), 32'(w[19:4]));
    chk({req, " ctrl12"}, 32'(c12), 32'(w[27:24]));
    chk({req, " data12"}, 32'(d12), 32'(w[19:4] & 16'hFFF0));
  endtask

  initial begin
    #2_000_000;
    if (!fin) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: run did not complete");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int c0, e0;
    logic [31:0] w, last;
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(3);

    // R8 reset state
    chk("R8 reset outputs", {v16, e16, c16, a16, d16}, 32'h0);
    chk("R8 reset counts", 32'(n_cmd16 + n_err16), 32'h0);

    // R1 clocks with select high are ignored
    for (int i = 0; i < 40; i++) sclk_pulse(i[0]);
    wait_cyc(8);
    chk("R1 no cmd while deselected", 32'(n_cmd16), 32'h0);
    chk("R1 no error while deselected", 32'(n_err16), 32'h0);
    chk("R1 outputs untouched", {c16, a16, d16}, 32'h0);

    // R2 R6 R7 sweep over every control and address value
    for (int c = 0; c < 16; c++) begin
      for (int a = 0; a < 16; a++) begin
        w = mk(c, a, 16'(c * 4369 + a * 257 + 7));
        c0 = n_cmd16;
        send(w, 32, 0, 1'b1);
        chk("R2 one cmd per word", 32'(n_cmd16 - c0), 32'h1);
        cmp_word("R2 R6 R7 fields", w);
      end
    end
    chk("R6 cmd count 12-bit", 32'(n_cmd12), 32'(n_cmd16));

    // R7 prefix all ones vs all zeros gives same fields
    w = 32'hF5A3C96F;
    send(w, 32, 0, 1'b1);
    cmp_word("R7 prefix ones", w);

    // R4 strobe before select rises
    w = 32'h09B1234F;
    c0 = n_cmd16;
    send(w, 32, 0, 1'b0);
    chk("R4 strobe with select low", 32'(n_cmd16 - c0), 32'h1);
    chk("R4 select still low", 32'(sel_n), 32'h0);
    cmp_word("R4 fields", w);
    sel_n = 1'b1;
    wait_cyc(2*HALF + 4);
    chk("R4 no error at late rise", 32'(n_err16), 32'h0);

    // R3 extra clocks after lock
    w = 32'h03C5E11B;
    c0 = n_cmd16;
    send(w, 32, 9, 1'b0);
    chk("R3 single strobe with extra clocks", 32'(n_cmd16 - c0), 32'h1);
    cmp_word("R3 fields unchanged", w);
    sel_n = 1'b1;
    wait_cyc(2*HALF + 4);
    chk("R3 no error after extra clocks", 32'(n_err16), 32'h0);
    last = w;

    // R5 every short length
    for (int n = 0; n < 32; n++) begin
      c0 = n_cmd16;
      e0 = n_err16;
      send(~last, n, 0, 1'b1);
      chk("R5 error pulse", 32'(n_err16 - e0), 32'h1);
      chk("R5 no cmd", 32'(n_cmd16 - c0), 32'h0);
      chk("R5 fields held", {c16, a16, d16}, {last[27:24], last[23:20], last[19:4]});
    end
    chk("R5 12-bit error count", 32'(n_err12), 32'(n_err16));

    // R1 a fresh frame after the aborts still decodes
    w = 32'h0E7FFFF0;
    send(w, 32, 0, 1'b1);
    cmp_word("R1 recovery", w);
    chk("R8 no stray strobe", {31'h0, v16}, 32'h0);

    fin = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule